// File: doc/BRIEF.md
# Dual-clock FIFO with retransmit

This block is an 18-bit first-in first-out buffer with a write port and a read port, each with its own free-running clock and enable. The two clocks may be one net or unrelated. A dual-port RAM inside the block holds the words. Positions cross between the clock domains as Gray code through two-stage synchronisers. The write side computes Full, Half-Full and programmable Almost-Full. The read side computes Empty and programmable Almost-Empty.

A small offset register in the write domain holds the two almost-flag thresholds. Software loads one of them per write clock. A retransmit strobe on the read side moves the read position back to the first word written since reset, so the stored sequence can be read out again. Read data comes from an output register. An output enable forces the data output to zero while it is low.

Top module: `dcfifo_rt`

## Requirements
- R1: On a write-clock rising edge with we_i high and full_o low, the block stores d_i. Holding we_i high stores one word per edge, and full_o rises once DEPTH words are held.
- R2: On a read-clock rising edge with re_i high, rt_i low and empty_o low, the block loads the oldest unread word into the output register. Words come out in the order they were written.
- R3: A write presented while full_o is high is dropped. No stored word and no position changes.
- R4: A read presented while empty_o is high is dropped, and the output register keeps its value.
- R5: empty_o is high when the read position equals the write position as seen through the two-stage synchroniser, so a write shows at empty_o two read edges later. full_o is built the same way from the synchronised read position.
- R6: half_o is high when the occupancy seen in the write domain is greater than DEPTH/2.
- R7: afull_o is high when DEPTH minus the write-domain occupancy is at or below the full offset. aempty_o is high when the read-domain occupancy is at or below the empty offset.
- R8: A write-clock edge with ofs_we_i high loads ofs_val_i into the empty offset when ofs_sel_i is 0, and into the full offset when ofs_sel_i is 1. Reset sets both offsets to 127.
- R9: A read-clock edge with rt_i high sets the read position to 0, which is the first word written since reset, and overrides re_i. This holds while no more than DEPTH words have been written since reset.
- R10: q_o carries the output register when oe_i is 1 and is all zeros when oe_i is 0.
- R11: While rst_ni is low, both positions clear, empty_o and aempty_o are 1, full_o, half_o and afull_o are 0, and the output register is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| we_i | input | 1 | Write enable |
| d_i | input | 18 | Write data |
| re_i | input | 1 | Read enable |
| rt_i | input | 1 | Retransmit strobe (read domain) |
| oe_i | input | 1 | Output enable for q_o |
| q_o | output | 18 | Registered read data, zero when disabled |
| ofs_we_i | input | 1 | Offset register load strobe (write domain) |
| ofs_sel_i | input | 1 | 0 selects the empty offset, 1 the full offset |
| ofs_val_i | input | 8 | Offset value to load |
| empty_o | output | 1 | Empty flag |
| full_o | output | 1 | Full flag |
| half_o | output | 1 | Half-Full flag |
| aempty_o | output | 1 | Programmable Almost-Empty flag |
| afull_o | output | 1 | Programmable Almost-Full flag |

## Verification
The clocks are tied together so that a queue-based model can predict every flag and data word cycle by cycle, including the two-edge synchroniser lag.

- **Short burst then drain:** separates plain ordering from pointer-wrap faults.
- **Fill past DEPTH, then drain past empty:** shows whether overflow words leak into storage and whether underflow reads disturb the output register.
- **Continuous simultaneous read and write:** tests the flags while both positions move on the same edge.
- **Offset loads at chosen occupancies:** separates the two threshold selectors from their comparisons.
- **Retransmit with re_i held high:** shows that replay wins over an ordinary read.
- **Long random mix with output-enable toggling:** covers wrap-around and masking.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  typedef enum logic {
    OFS_EMPTY = 1'b0,
    OFS_FULL  = 1'b1
  } ofs_sel_e;

  localparam int SYNC_STAGES = 2;
  localparam int OFS_RESET   = 127;
endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int W      = 9,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) st[0] <= '0;
        else         st[0] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) st[g] <= '0;
        else         st[g] <= st[g-1];
    end
  end

  assign q_o = st[STAGES-1];
endmodule

// File: rtl/dcf_ram.sv
module dcf_ram #(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              wclk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rclk_i,
  input  logic              rst_ni,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wclk_i)
    if (we_i) mem[waddr_i] <= wdata_i;

  // output register, cleared by reset
  always_ff @(posedge rclk_i or negedge rst_ni)
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= mem[raddr_i];
endmodule

// File: rtl/dcf_wr_ctrl.sv
module dcf_wr_ctrl #(
  parameter int ADDR_W = 8,
  localparam int PW    = ADDR_W + 1,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [PW-1:0]     rgray_s_i,
  input  logic [ADDR_W-1:0] af_ofs_i,
  output logic [PW-1:0]     wbin_o,
  output logic [PW-1:0]     wgray_o,
  output logic              push_o,
  output logic              full_o,
  output logic              half_o,
  output logic              afull_o
);
  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PW-1:0] rbin_s, occ, free, wnext;

  assign rbin_s  = g2b(rgray_s_i);
  assign occ     = wbin_o - rbin_s;
  assign free    = PW'(DEPTH) - occ;
  assign full_o  = (occ == PW'(DEPTH));
  assign half_o  = (occ > PW'(DEPTH / 2));
  assign afull_o = (free <= {1'b0, af_ofs_i});
  assign push_o  = we_i & ~full_o;
  assign wnext   = wbin_o + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      wbin_o  <= '0;
      wgray_o <= '0;
    end else if (push_o) begin
      wbin_o  <= wnext;
      wgray_o <= wnext ^ (wnext >> 1);
    end
endmodule

// File: rtl/dcf_rd_ctrl.sv
module dcf_rd_ctrl #(
  parameter int ADDR_W = 8,
  localparam int PW    = ADDR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              re_i,
  input  logic              rt_i,
  input  logic [PW-1:0]     wgray_s_i,
  input  logic [ADDR_W-1:0] ae_ofs_i,
  output logic [PW-1:0]     rbin_o,
  output logic [PW-1:0]     rgray_o,
  output logic              pop_o,
  output logic              empty_o,
  output logic              aempty_o
);
  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PW-1:0] wbin_s, occ, rnext;

  assign wbin_s   = g2b(wgray_s_i);
  assign occ      = wbin_s - rbin_o;
  assign empty_o  = (occ == '0);
  assign aempty_o = (occ <= {1'b0, ae_ofs_i});
  // retransmit wins over a read in the same cycle
  assign pop_o    = re_i & ~rt_i & ~empty_o;
  assign rnext    = rt_i ? '0 : rbin_o + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      rbin_o  <= '0;
      rgray_o <= '0;
    end else if (rt_i || pop_o) begin
      rbin_o  <= rnext;
      rgray_o <= rnext ^ (rnext >> 1);
    end
endmodule

// File: rtl/dcfifo_rt.sv
module dcfifo_rt #(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 8
) (
  input  logic              wclk_i,
  input  logic              rclk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] d_i,
  input  logic              re_i,
  input  logic              rt_i,
  input  logic              oe_i,
  output logic [DATA_W-1:0] q_o,
  input  logic              ofs_we_i,
  input  logic              ofs_sel_i,
  input  logic [ADDR_W-1:0] ofs_val_i,
  output logic              empty_o,
  output logic              full_o,
  output logic              half_o,
  output logic              aempty_o,
  output logic              afull_o
);
  import dcf_pkg::*;

  localparam int PW = ADDR_W + 1;

  logic [PW-1:0]     wr_bin, wr_gray, rd_bin, rd_gray, wr_gray_s, rd_gray_s;
  logic              push, pop;
  logic [ADDR_W-1:0] ae_ofs, af_ofs;
  logic [DATA_W-1:0] dq;

  // almost-flag thresholds, write domain
  always_ff @(posedge wclk_i or negedge rst_ni)
    if (!rst_ni) begin
      ae_ofs <= ADDR_W'(OFS_RESET);
      af_ofs <= ADDR_W'(OFS_RESET);
    end else if (ofs_we_i) begin
      if (ofs_sel_e'(ofs_sel_i) == OFS_FULL) af_ofs <= ofs_val_i;
      else                                   ae_ofs <= ofs_val_i;
    end

  dcf_wr_ctrl #(.ADDR_W(ADDR_W)) u_wr (
    .clk_i(wclk_i), .rst_ni(rst_ni), .we_i(we_i), .rgray_s_i(rd_gray_s),
    .af_ofs_i(af_ofs), .wbin_o(wr_bin), .wgray_o(wr_gray), .push_o(push),
    .full_o(full_o), .half_o(half_o), .afull_o(afull_o)
  );

  dcf_rd_ctrl #(.ADDR_W(ADDR_W)) u_rd (
    .clk_i(rclk_i), .rst_ni(rst_ni), .re_i(re_i), .rt_i(rt_i),
    .wgray_s_i(wr_gray_s), .ae_ofs_i(ae_ofs), .rbin_o(rd_bin), .rgray_o(rd_gray),
    .pop_o(pop), .empty_o(empty_o), .aempty_o(aempty_o)
  );

  dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
    .clk_i(rclk_i), .rst_ni(rst_ni), .d_i(wr_gray), .q_o(wr_gray_s)
  );

  dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
    .clk_i(wclk_i), .rst_ni(rst_ni), .d_i(rd_gray), .q_o(rd_gray_s)
  );

  dcf_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .wclk_i(wclk_i), .we_i(push), .waddr_i(wr_bin[ADDR_W-1:0]), .wdata_i(d_i),
    .rclk_i(rclk_i), .rst_ni(rst_ni), .re_i(pop), .raddr_i(rd_bin[ADDR_W-1:0]),
    .rdata_o(dq)
  );

  assign q_o = oe_i ? dq : '0;
endmodule

// File: rtl/dcf_checker.sv
module dcf_checker #(
  parameter int PW = 9
) (
  input logic          wclk_i,
  input logic          rclk_i,
  input logic          rst_ni,
  input logic          we_i,
  input logic          re_i,
  input logic          rt_i,
  input logic          full_i,
  input logic          half_i,
  input logic          afull_i,
  input logic          empty_i,
  input logic          aempty_i,
  input logic [PW-1:0] wr_ptr_i,
  input logic [PW-1:0] rd_ptr_i
);
  // R3
  p_no_overflow_r3: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    full_i && we_i |=> $stable(wr_ptr_i));

  // R4
  p_no_underflow_r4: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    empty_i && re_i && !rt_i |=> $stable(rd_ptr_i));

  // R9
  p_rt_rewind_r9: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    rt_i |=> rd_ptr_i == '0);

  // R6
  p_full_half_r6: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    full_i |-> half_i);

  // R7
  p_full_afull_r7: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    full_i |-> afull_i);

  // R7
  p_empty_aempty_r7: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    empty_i |-> aempty_i);
endmodule

bind dcfifo_rt dcf_checker #(.PW(ADDR_W + 1)) u_chk (
  .wclk_i(wclk_i), .rclk_i(rclk_i), .rst_ni(rst_ni), .we_i(we_i), .re_i(re_i),
  .rt_i(rt_i), .full_i(full_o), .half_i(half_o), .afull_i(afull_o),
  .empty_i(empty_o), .aempty_i(aempty_o), .wr_ptr_i(wr_bin), .rd_ptr_i(rd_bin)
);

// File: tb/sim_dcfifo_rt.sv
module sim_dcfifo_rt;
  localparam int DW = 18, AW = 8, DEPTH = 1 << AW, PM = 2 * DEPTH - 1;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, we = 1'b0, re = 1'b0, rt = 1'b0, oe = 1'b1;
  logic ofs_we = 1'b0, ofs_sel = 1'b0;
  logic [DW-1:0] d = '0;
  logic [AW-1:0] ofs_val = '0;
  logic [DW-1:0] q;
  logic empty, full, half, aempty, afull;

  dcfifo_rt #(.DATA_W(DW), .ADDR_W(AW)) u0 (
    .wclk_i(clk), .rclk_i(clk), .rst_ni(rst_n), .we_i(we), .d_i(d), .re_i(re),
    .rt_i(rt), .oe_i(oe), .q_o(q), .ofs_we_i(ofs_we), .ofs_sel_i(ofs_sel),
    .ofs_val_i(ofs_val), .empty_o(empty), .full_o(full), .half_o(half),
    .aempty_o(aempty), .afull_o(afull)
  );

  // reference model state
  int m_wp, m_rp, m_ws1, m_ws2, m_rs1, m_rs2, m_ae, m_af;
  logic [DW-1:0] m_mem [DEPTH];
  logic [DW-1:0] m_dq;
  int n_chk = 0, n_fail = 0;
  string tag_q = "R2";

  function automatic int occ_w(); return (m_wp - m_rs2) & PM; endfunction
  function automatic int occ_r(); return (m_ws2 - m_rp) & PM; endfunction
  function automatic bit e_full();   return occ_w() == DEPTH; endfunction
  function automatic bit e_half();   return occ_w() > DEPTH / 2; endfunction
  function automatic bit e_afull();  return (DEPTH - occ_w()) <= m_af; endfunction
  function automatic bit e_empty();  return occ_r() == 0; endfunction
  function automatic bit e_aempty(); return occ_r() <= m_ae; endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_wp = 0; m_rp = 0; m_ws1 = 0; m_ws2 = 0; m_rs1 = 0; m_rs2 = 0;
    m_ae = 127; m_af = 127; m_dq = '0;
  endtask

  task automatic model_edge();
    bit aw, ar;
    int owp, orp;
    aw = we && !e_full();
    ar = re && !rt && !e_empty();
    owp = m_wp; orp = m_rp;
    m_ws2 = m_ws1; m_ws1 = owp;
    m_rs2 = m_rs1; m_rs1 = orp;
    if (aw) begin
      m_mem[m_wp % DEPTH] = d;
      m_wp = (m_wp + 1) & PM;
    end
    if (rt) m_rp = 0;
    else if (ar) begin
      m_dq = m_mem[m_rp % DEPTH];
      m_rp = (m_rp + 1) & PM;
    end
    if (ofs_we) begin
      if (ofs_sel) m_af = int'(ofs_val);
      else         m_ae = int'(ofs_val);
    end
  endtask

  task automatic compare_all();
    chk("R5", "empty_o", 32'(empty), 32'(e_empty()));
    chk("R5", "full_o", 32'(full), 32'(e_full()));
    chk("R6", "half_o", 32'(half), 32'(e_half()));
    chk("R7", "aempty_o", 32'(aempty), 32'(e_aempty()));
    chk("R7", "afull_o", 32'(afull), 32'(e_afull()));
    if (oe) chk(tag_q, "q_o", 32'(q), 32'(m_dq));
    else    chk("R10", "q_o masked", 32'(q), 32'd0);
  endtask

  task automatic cyc();
    @(posedge clk);
    if (rst_n) model_edge();
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle();
    we = 0; re = 0; rt = 0; ofs_we = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle();
    rst_n = 0;
    model_reset();
    repeat (3) @(negedge clk);
    chk("R11", "empty_o", 32'(empty), 32'd1);
    chk("R11", "aempty_o", 32'(aempty), 32'd1);
    chk("R11", "full_o", 32'(full), 32'd0);
    chk("R11", "half_o", 32'(half), 32'd0);
    chk("R11", "afull_o", 32'(afull), 32'd0);
    chk("R11", "q_o", 32'(q), 32'd0);
    rst_n = 1;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [DW-1:0] first;
    do_reset();

    // R1 R2: short burst then drain
    tag_q = "R2";
    we = 1;
    for (int i = 0; i < 5; i++) begin d = DW'(i * 37 + 5); cyc(); end
    we = 0;
    repeat (3) cyc();
    re = 1;
    repeat (7) cyc();
    re = 0;

    // R1 R3: fill past DEPTH
    tag_q = "R3";
    we = 1;
    for (int i = 0; i < DEPTH + 4; i++) begin d = DW'(i); cyc(); end
    we = 0;
    repeat (3) cyc();
    chk("R1", "full_o after DEPTH writes", 32'(full), 32'd1);
    re = 1;
    repeat (DEPTH + 2) cyc();
    chk("R3", "last stored word", 32'(q), 32'(DEPTH - 1));
    // R4: reads while empty
    tag_q = "R4";
    repeat (5) cyc();
    re = 0;
    chk("R4", "q_o held after empty reads", 32'(q), 32'(DEPTH - 1));
    chk("R4", "empty_o", 32'(empty), 32'd1);

    // R2: simultaneous streaming
    tag_q = "R2";
    we = 1; re = 1;
    for (int i = 0; i < 300; i++) begin d = DW'($urandom); cyc(); end
    idle();
    repeat (4) cyc();

    // R8 R7: offsets
    do_reset();
    tag_q = "R7";
    ofs_we = 1; ofs_sel = 0; ofs_val = 8'd3; cyc();
    ofs_sel = 1; ofs_val = 8'd5; cyc();
    ofs_we = 0;
    we = 1;
    for (int i = 0; i < 4; i++) begin d = DW'(i + 100); cyc(); end
    we = 0;
    repeat (3) cyc();
    chk("R8", "aempty_o at occ 4, ofs 3", 32'(aempty), 32'd0);
    re = 1; cyc(); re = 0;
    repeat (3) cyc();
    chk("R8", "aempty_o at occ 3, ofs 3", 32'(aempty), 32'd1);
    we = 1;
    for (int i = 0; i < DEPTH - 9; i++) begin d = DW'(i); cyc(); end
    we = 0;
    repeat (3) cyc();
    chk("R8", "afull_o at free 6, ofs 5", 32'(afull), 32'd0);
    we = 1; d = 18'h3abcd; cyc(); we = 0;
    repeat (3) cyc();
    chk("R8", "afull_o at free 5, ofs 5", 32'(afull), 32'd1);
    chk("R6", "half_o near full", 32'(half), 32'd1);

    // R9: retransmit
    do_reset();
    tag_q = "R9";
    we = 1;
    for (int i = 0; i < 10; i++) begin
      d = DW'($urandom);
      if (i == 0) first = d;
      cyc();
    end
    we = 0;
    repeat (3) cyc();
    re = 1;
    repeat (6) cyc();
    rt = 1; cyc(); rt = 0;
    cyc();
    chk("R9", "first word replayed", 32'(q), 32'(first));
    repeat (12) cyc();
    re = 0;

    // R10: output enable masking
    we = 1; d = 18'h15555; cyc(); we = 0;
    repeat (3) cyc();
    re = 1; cyc(); re = 0;
    oe = 0;
    cyc();
    chk("R10", "q_o zero with oe low", 32'(q), 32'd0);
    oe = 1;
    cyc();
    chk("R10", "q_o restored", 32'(q), 32'h15555);

    // random mix
    do_reset();
    tag_q = "R2";
    for (int i = 0; i < 3000; i++) begin
      we = ($urandom % 3) != 0;
      re = ($urandom % 5) < 3;
      oe = ($urandom % 8) != 0;
      d = DW'($urandom);
      ofs_we = ($urandom % 97) == 0;
      ofs_sel = 1'($urandom);
      ofs_val = AW'($urandom);
      cyc();
    end
    idle();
    oe = 1;
    repeat (4) cyc();

    finish_run();
  end
endmodule